// File: doc/BRIEF.md
# Desaturation Fault and Ready Supervisor

This block is the digital supervisor on the output side of an isolated gate driver. It watches a digitised desaturation comparator while the power switch is commanded on. It ignores that comparator for a fixed blanking window after each turn-on. A trip after the window latches a fault. The fault drives an active-low fault flag and requests that the gate be forced off. The fault is released only through the active-low clear pin. The pin must be held low for a minimum number of clock ticks, and the release happens on its rising edge.

A ready flag reports whether the driver may switch. It has no latch and follows three conditions. The input-side supply must be good. The output-side supply must have been good for a short qualification delay. The isolation link must have shown activity within the watchdog window. Whenever ready is low or the fault is latched, the forced-off request is high, whatever the gate command is.

The fault machine has four states, all reset synchronously. `ST_OFF` is idle with the gate off. `ST_BLANK` counts the blanking ticks after a turn-on. `ST_ARMED` means the gate is on and trips are accepted. `ST_TRIPPED` means the fault is latched. The transitions are:
- `ST_OFF` to `ST_BLANK` when the gate is commanded on and ready is high.
- `ST_BLANK` to `ST_ARMED` when the last blanking tick is reached.
- `ST_BLANK` to `ST_OFF` when the gate command drops or ready is lost.
- `ST_ARMED` to `ST_TRIPPED` when the gate command and the desaturation bit are both high.
- `ST_ARMED` to `ST_OFF` when the gate command drops or ready is lost.
- `ST_TRIPPED` to `ST_OFF` on a qualified clear.
- During block reset, the state is loaded with `ST_TRIPPED` if the desaturation bit is high, and with `ST_OFF` otherwise.

Top module: `desat_fault_supervisor`

## Requirements
- R1: After a block reset with the desaturation bit low, the fault flag is 1, ready is 0 until a link pulse is seen, and the forced-off request is 1.
- R2: If the desaturation bit is high while the block reset is active, the fault flag is 0 once reset is released.
- R3: The desaturation bit is ignored at the first sampling edge where the gate command is high and at the BLANK_TICKS edges that follow.
- R4: A desaturation bit sampled high while the gate is commanded on, after blanking, drives the fault flag to 0 one edge later and holds it there.
- R5: While the gate command is low, the desaturation bit has no effect on the fault flag.
- R6: A rising edge of the clear pin, after the pin was sampled low at RST_MIN_TICKS or more consecutive edges, returns the fault flag to 1 after that edge.
- R7: A rising edge of the clear pin after fewer than RST_MIN_TICKS low edges leaves a latched fault in place. A clear pulse of any length leaves an unlatched fault flag at 1.
- R8: Ready is 1 only while the input-supply bit is 1, the output supply is qualified and the link is healthy. A 0 on the input-supply bit lowers ready in the same cycle.
- R9: Ready falls after WDOG_TICKS consecutive edges with no link pulse sampled. It rises again one edge after a link pulse, if the other conditions hold.
- R10: The forced-off request is 1 whenever the fault is latched or ready is 0, and 0 otherwise.
- R11: The output supply is qualified only after its bit has been sampled 1 on VOUT_DLY consecutive edges. It is disqualified one edge after that bit is sampled 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, 20 MHz nominal |
| rst_n | input | 1 | Synchronous active-low block reset |
| gate_on_i | input | 1 | Gate commanded on |
| desat_hit_i | input | 1 | Digitised desaturation comparator output |
| vin_ok_i | input | 1 | Input-side supply above lockout |
| vout_ok_i | input | 1 | Output-side supply above lockout |
| link_pulse_i | input | 1 | Activity strobe from the isolation link |
| clr_pin_n_i | input | 1 | Active-low fault clear pin |
| fault_n_o | output | 1 | Fault flag, 0 while a fault is latched |
| ready_o | output | 1 | Driver ready |
| force_off_o | output | 1 | Request to hold the gate at the negative rail |

## Verification
A trip, a qualified clear, a watchdog expiry, a link recovery and an output-supply drop each show at the outputs one edge after the edge that samples their cause. A drop of the input supply lowers ready and raises the forced-off request at once, with no edge in between. The bench drives its inputs and samples the outputs on the falling clock edge. It steps a cycle-accurate model from the requirements on every rising edge, so each output is compared in the half-cycle after the edge that made it due. The directed cases count exact edge totals at the blanking, clear-width and watchdog limits: one edge short of each limit and exactly at it.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_BLANK,
        ST_ARMED,
        ST_TRIPPED
    } dfs_state_e;
endpackage

// File: rtl/dfs_clr_qual.sv
// Qualifies the fault clear pin: a rising edge counts only after a long enough low phase.
module dfs_clr_qual #(
    parameter int MIN_LOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic clr_ok_o
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] LIM = LW'(MIN_LOW);

    logic          pin_q;
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q   <= 1'b1;
            low_cnt <= '0;
        end else begin
            pin_q <= pin_n_i;
            if (pin_n_i)
                low_cnt <= '0;
            else if (low_cnt != LIM)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign clr_ok_o = pin_n_i && !pin_q && (low_cnt >= LIM);
endmodule

// File: rtl/dfs_ready_mon.sv
// Combines supply status with a link activity watchdog into the ready flag.
module dfs_ready_mon #(
    parameter int VOUT_DLY   = 8,
    parameter int WDOG_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin_ok_i,
    input  logic vout_ok_i,
    input  logic link_pulse_i,
    output logic ready_o
);
    localparam int VW = $clog2(VOUT_DLY + 1);
    localparam int WW = $clog2(WDOG_TICKS + 1);
    localparam logic [VW-1:0] V_LIM = VW'(VOUT_DLY);
    localparam logic [WW-1:0] W_LAST = WW'(WDOG_TICKS - 1);

    logic [VW-1:0] vout_cnt;
    logic [WW-1:0] idle_cnt;
    logic          link_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vout_cnt <= '0;
        end else if (!vout_ok_i) begin
            vout_cnt <= '0;
        end else if (vout_cnt != V_LIM) begin
            vout_cnt <= vout_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            link_ok  <= 1'b0;
        end else if (link_pulse_i) begin
            idle_cnt <= '0;
            link_ok  <= 1'b1;
        end else if (idle_cnt == W_LAST) begin
            link_ok  <= 1'b0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign ready_o = vin_ok_i && (vout_cnt == V_LIM) && link_ok;
endmodule

// File: rtl/dfs_fault_fsm.sv
// Blanking, trip acceptance and fault latch.
module dfs_fault_fsm
    import dfs_pkg::*;
#(
    parameter int BLANK_TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on_i,
    input  logic desat_hit_i,
    input  logic sys_ok_i,
    input  logic clr_ok_i,
    output logic fault_n_o,
    output logic tripped_o
);
    localparam int BW = $clog2(BLANK_TICKS + 1);
    localparam logic [BW-1:0] B_LAST = BW'(BLANK_TICKS - 1);

    dfs_state_e    state, nxt;
    logic [BW-1:0] blank_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= desat_hit_i ? ST_TRIPPED : ST_OFF;
            blank_cnt <= '0;
        end else begin
            state     <= nxt;
            blank_cnt <= (state == ST_BLANK && nxt == ST_BLANK) ? blank_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (gate_on_i && sys_ok_i)
                    nxt = ST_BLANK;
            end
            ST_BLANK: begin
                if (!gate_on_i || !sys_ok_i)
                    nxt = ST_OFF;
                else if (blank_cnt == B_LAST)
                    nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (gate_on_i && desat_hit_i)
                    nxt = ST_TRIPPED;
                else if (!gate_on_i || !sys_ok_i)
                    nxt = ST_OFF;
            end
            ST_TRIPPED: begin
                if (clr_ok_i)
                    nxt = ST_OFF;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        tripped_o = (state == ST_TRIPPED);
        fault_n_o = !tripped_o;
    end
endmodule

// File: rtl/desat_fault_supervisor.sv
module desat_fault_supervisor #(
    parameter int BLANK_TICKS   = 40,
    parameter int RST_MIN_TICKS = 16,
    parameter int VOUT_DLY      = 8,
    parameter int WDOG_TICKS    = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on_i,
    input  logic desat_hit_i,
    input  logic vin_ok_i,
    input  logic vout_ok_i,
    input  logic link_pulse_i,
    input  logic clr_pin_n_i,
    output logic fault_n_o,
    output logic ready_o,
    output logic force_off_o
);
    logic clr_ok;
    logic tripped;

    dfs_clr_qual #(.MIN_LOW(RST_MIN_TICKS)) u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n_i  (clr_pin_n_i),
        .clr_ok_o (clr_ok)
    );

    dfs_ready_mon #(.VOUT_DLY(VOUT_DLY), .WDOG_TICKS(WDOG_TICKS)) u_rdy (
        .clk          (clk),
        .rst_n        (rst_n),
        .vin_ok_i     (vin_ok_i),
        .vout_ok_i    (vout_ok_i),
        .link_pulse_i (link_pulse_i),
        .ready_o      (ready_o)
    );

    dfs_fault_fsm #(.BLANK_TICKS(BLANK_TICKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_on_i   (gate_on_i),
        .desat_hit_i (desat_hit_i),
        .sys_ok_i    (ready_o),
        .clr_ok_i    (clr_ok),
        .fault_n_o   (fault_n_o),
        .tripped_o   (tripped)
    );

    assign force_off_o = tripped || !ready_o;
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
    parameter int WDOG_TICKS = 200
) (
    input logic clk,
    input logic rst_n,
    input logic gate_on_i,
    input logic desat_hit_i,
    input logic vin_ok_i,
    input logic vout_ok_i,
    input logic link_pulse_i,
    input logic clr_pin_n_i,
    input logic fault_n_o,
    input logic ready_o,
    input logic force_off_o
);
    localparam int WW = $clog2(WDOG_TICKS + 1);
    localparam logic [WW-1:0] W_LIM = WW'(WDOG_TICKS);

    logic [WW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            quiet_cnt <= '0;
        else if (link_pulse_i)
            quiet_cnt <= '0;
        else if (quiet_cnt != W_LIM)
            quiet_cnt <= quiet_cnt + 1'b1;
    end

    a_r10_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n_o |-> force_off_o);
    a_r10_unready_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> force_off_o);
    a_r8_vin_gates_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_ok_i |-> !ready_o);
    a_r11_vout_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !vout_ok_i |=> !ready_o);
    a_r4_fault_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n_o) |-> ($past(desat_hit_i) && (!$past(rst_n) || $past(gate_on_i))));
    a_r6_clear_on_rising_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n_o) |-> (!$past(rst_n) || ($past(clr_pin_n_i) && !$past(clr_pin_n_i, 2))));
    a_r9_watchdog_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt == W_LIM) |-> !ready_o);
endmodule

bind desat_fault_supervisor dfs_checker #(.WDOG_TICKS(WDOG_TICKS)) u_chk (.*);

// File: tb/desat_fault_supervisor_bench.sv
module desat_fault_supervisor_bench;
    localparam int BT = 40;
    localparam int RM = 16;
    localparam int VD = 8;
    localparam int WD = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_on = 1'b0, desat = 1'b0, vin = 1'b1, vout = 1'b1, link = 1'b0, pin = 1'b1;
    logic fault_n, ready, force_off;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    // model state: 0 off, 1 blank, 2 armed, 3 tripped
    int m_st = 0, m_bc = 0, m_lo = 0, m_vc = 0, m_idle = 0;
    bit m_pq = 1'b1, m_link = 1'b0;

    always #10 clk = ~clk;

    desat_fault_supervisor #(.BLANK_TICKS(BT), .RST_MIN_TICKS(RM), .VOUT_DLY(VD), .WDOG_TICKS(WD))
    u_desat_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .gate_on_i(gate_on), .desat_hit_i(desat),
        .vin_ok_i(vin), .vout_ok_i(vout), .link_pulse_i(link), .clr_pin_n_i(pin),
        .fault_n_o(fault_n), .ready_o(ready), .force_off_o(force_off));

    function automatic bit m_ready();
        return vin && (m_vc == VD) && m_link;
    endfunction

    function automatic int m_next(bit ok, bit clr);
        int n;
        n = m_st;
        case (m_st)
            0: if (gate_on && ok) n = 1;
            1: if (!gate_on || !ok) n = 0; else if (m_bc == BT - 1) n = 2;
            2: if (gate_on && desat) n = 3; else if (!gate_on || !ok) n = 0;
            default: if (clr) n = 0;
        endcase
        return n;
    endfunction

    task automatic model_edge();
        bit ok, clr;
        int n;
        if (!rst_n) begin
            m_st = desat ? 3 : 0; m_bc = 0; m_pq = 1'b1; m_lo = 0;
            m_vc = 0; m_idle = 0; m_link = 1'b0;
        end else begin
            ok  = m_ready();
            clr = pin && !m_pq && (m_lo >= RM);
            n   = m_next(ok, clr);
            m_bc = (n == 1 && m_st == 1) ? m_bc + 1 : 0;
            m_st = n;
            m_pq = pin;
            if (pin) m_lo = 0; else if (m_lo < RM) m_lo++;
            if (!vout) m_vc = 0; else if (m_vc < VD) m_vc++;
            if (link) begin m_idle = 0; m_link = 1'b1; end
            else if (m_idle == WD - 1) m_link = 1'b0;
            else m_idle++;
        end
    endtask

    task automatic check(bit got, bit exp, string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: got %0b expected %0b", tag, cyc, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst_n) begin
            check(fault_n, !(m_st == 3), "R4 fault flag vs model");
            check(ready, m_ready(), "R8 ready vs model");
            check(force_off, (m_st == 3) || !m_ready(), "R10 forced-off vs model");
        end
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic qualified_clear();
        pin = 1'b0; steps(RM);
        pin = 1'b1; step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected below 200000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int starve, pin_hold;
        void'($urandom(32'd1234));
        // R1 reset state
        steps(2);
        rst_n = 1'b1; step();
        check(fault_n, 1'b1, "R1 fault flag after reset");
        check(ready, 1'b0, "R1 ready before link pulse");
        check(force_off, 1'b1, "R1 forced off after reset");
        // R2 reset with trip present
        rst_n = 1'b0; desat = 1'b1; step();
        rst_n = 1'b1; desat = 1'b0; step();
        check(fault_n, 1'b0, "R2 fault latched at reset");
        // R7 short clear, then R6 qualified clear
        pin = 1'b0; steps(RM - 1);
        pin = 1'b1; step();
        check(fault_n, 1'b0, "R7 short clear ignored");
        qualified_clear();
        check(fault_n, 1'b1, "R6 qualified clear");
        pin = 1'b0; steps(RM + 10);
        pin = 1'b1; step();
        check(fault_n, 1'b1, "R7 clear with no fault");
        // R8 link up
        link = 1'b1; steps(VD + 2);
        check(ready, 1'b1, "R8 ready with all conditions");
        // R5 trip with gate off
        desat = 1'b1; steps(5);
        check(fault_n, 1'b1, "R5 trip ignored while off");
        desat = 1'b0; step();
        // R3 blanking, R4 trip
        gate_on = 1'b1; desat = 1'b1; steps(BT + 1);
        check(fault_n, 1'b1, "R3 trip blanked");
        step();
        check(fault_n, 1'b0, "R4 trip after blanking");
        check(force_off, 1'b1, "R4 trip forces off");
        gate_on = 1'b0; desat = 1'b0;
        qualified_clear();
        check(force_off, 1'b0, "R10 released when ready and clear");
        // R9 watchdog
        link = 1'b0; steps(WD - 1);
        check(ready, 1'b1, "R9 ready one edge before expiry");
        step();
        check(ready, 1'b0, "R9 watchdog expiry");
        link = 1'b1; step();
        check(ready, 1'b1, "R9 recovery on link pulse");
        // R11 output supply delay
        vout = 1'b0; step();
        check(ready, 1'b0, "R11 vout drop");
        vout = 1'b1; steps(VD - 1);
        check(ready, 1'b0, "R11 still qualifying");
        step();
        check(ready, 1'b1, "R11 qualified");
        // R8 and R10 input supply immediate
        vin = 1'b0; #1;
        check(ready, 1'b0, "R8 vin drop immediate");
        check(force_off, 1'b1, "R10 forced off on vin drop");
        step();
        vin = 1'b1; step();
        // random phase
        starve = 0; pin_hold = 0;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 700 == 0) starve = 1 - starve;
            link = (starve == 0) && ($urandom % 100 < 30);
            if ($urandom % 60 == 0) gate_on = !gate_on;
            desat = ($urandom % 100 < 3);
            vin = ($urandom % 900 != 0);
            vout = ($urandom % 500 != 0);
            if (pin_hold > 0) begin
                pin = 1'b0; pin_hold--;
            end else begin
                pin = 1'b1;
                if ($urandom % 120 == 0) pin_hold = 1 + int'($urandom % 30);
            end
            step();
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule